// File: doc/BRIEF.md
# DSP Boot Sequencer

This block brings an attached signal processor from cold to running firmware. On a boot request it switches on the core rail, then the I/O rail, and then lets the device out of reset. It then walks a fixed ladder of public states: powered off, out of reset, boot ROM, stage 2 and firmware. Between phases it waits for a falling edge on the device's interrupt line. Each of these waits gives up after a programmable 20 ms. A timeout is recorded but does not stop the boot.

The block never moves bytes itself. It starts external download engines with a one-cycle start pulse and a kind code, and it takes their completion, a transport error and the verdicts of a response checker. It also tells the SPI clock generator which divider to use for each phase. The stage-2 loader goes out at sysclk/10. The PLL setup record goes out twice at sysclk/6, and only the answer to the second copy counts. The firmware goes out at sysclk/6, or at the PLL-derived rate once the PLL is confirmed.

Any failure drops the device straight back into reset with both rails off. A halt request does the same. A boot request with a system clock above the supported limit is refused.

Top module: `dsp_boot_seq`

## Requirements
- R1: `boot_state` encodes 0 powered off, 1 out of reset, 2 boot ROM, 3 stage 2, 4 firmware. A change of `boot_state` always goes either to the next code up or back to 0.
- R2: An accepted boot request raises `core_sup_en` at the next edge and `io_sup_en` one cycle later. One cycle after that, `dsp_rst` leaves its active level `RST_ACTIVE` and `boot_state` becomes 1. Outside state 0, both rails are on and reset is released.
- R3: A falling edge of `dsp_irq_n` is seen two clocks after it occurs, through a two-flop synchronizer. It is taken only while `boot_state` is 1, 2 or 3. An edge taken while no wait is active is held until the next wait uses it. Edges outside states 1 to 3 are dropped.
- R4: A wait with no interrupt ends after exactly CYC_PER_MS*TMO_MS cycles. It sets `irq_timeout` and the boot goes on. The first wait leads to state 2 and the second to state 3.
- R5: The stage-2 download is started with a one-cycle `dl_start`, with `dl_kind`=1 and `spi_div`=10. A completion that carries `dl_err` or `chk_bad` is a failure.
- R6: When `max_spi_hz` is nonzero, the PLL record is started twice with `dl_kind`=2 and `spi_div`=6. `pll_running` takes the value of `chk_pll_lock` at the end of the second send. `chk_bad` has no effect during either send, and `dl_err` is a failure. When `max_spi_hz` is zero, both sends are skipped.
- R7: The firmware download uses `dl_kind`=3. It runs at `spi_div`=6 while `pll_running` is 0, and at `spi_div`=0 (meaning: use `spi_pll_hz`) while it is 1. `spi_pll_hz` is the smaller of `max_spi_hz` and `board_max_hz`, where a `board_max_hz` of 0 means no board limit.
- R8: At the next edge after a failure, `boot_state` is 0, both rails are off, `dsp_rst` is at its active level, `boot_fail` is 1 and `pll_running` is 0.
- R9: In state 0, a boot request with `sysclk_hz` above MAX_SYSCLK_HZ (26,000,000) is refused. The block stays powered off and `boot_fail` becomes 1. A value exactly at the limit is accepted.
- R10: `halt_req` returns the block to state 0 from any other state and leaves `boot_fail` unchanged. `boot_req` has no effect outside state 0.
- R11: An accepted boot request clears `boot_fail` and `irq_timeout`. A successful boot ends in state 4 with `dl_kind`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_req | input | 1 | Single-cycle request to boot |
| halt_req | input | 1 | Single-cycle request to power down |
| sysclk_hz | input | RATE_W | Device system clock in Hz |
| max_spi_hz | input | RATE_W | SPI rate available once the PLL runs, 0 = do not set up the PLL |
| board_max_hz | input | RATE_W | Board SPI rate limit, 0 = none |
| dsp_irq_n | input | 1 | Device interrupt, active on a falling edge, asynchronous |
| dl_done | input | 1 | Download engine finished the current transfer |
| dl_err | input | 1 | Transport error, valid with dl_done |
| chk_bad | input | 1 | Response checker saw a bad reply, valid with dl_done |
| chk_pll_lock | input | 1 | Response contained the PLL-running word, valid with dl_done |
| boot_state | output | 3 | Public boot state code |
| core_sup_en | output | 1 | Core rail enable |
| io_sup_en | output | 1 | I/O rail enable |
| dsp_rst | output | 1 | Device reset, active level RST_ACTIVE |
| dl_start | output | 1 | One-cycle start for the download engine |
| dl_kind | output | 2 | 0 none, 1 stage-2 loader, 2 PLL record, 3 firmware |
| spi_div | output | 4 | SPI divider from sysclk, 0 = use spi_pll_hz |
| spi_pll_hz | output | RATE_W | SPI rate to use when spi_div is 0 |
| pll_running | output | 1 | PLL confirmed by the device |
| boot_fail | output | 1 | Last boot attempt failed or was refused |
| irq_timeout | output | 1 | An interrupt wait expired in this boot |

## Verification
Some properties are checked by the bound checker on every cycle:
- the rail and reset ordering against the public state;
- state changes being limited to one step up or a drop to zero;
- the one-cycle start pulse;
- a rising `boot_fail` coinciding with the powered-off outputs;
- a timeout only ever leading into state 2 or 3;
- `pll_running` rising only at the end of a PLL send;
- the zero divider during a firmware download with the PLL running.

Other behaviour appears only in the bench's scenarios, which a cycle-accurate reference model follows:
- the exact length of a timed-out wait;
- an interrupt taken during the stage-2 download being held for the next wait;
- edges in the powered-off state being dropped;
- the skipped PLL sends;
- the bad-reply flag being ignored while the PLL record goes out;
- the refusal at exactly one hertz above the clock limit.

// File: rtl/dsp_boot_pkg.sv
package dsp_boot_pkg;

    typedef enum logic [2:0] {
        BS_OFF  = 3'd0,
        BS_OOR  = 3'd1,
        BS_BROM = 3'd2,
        BS_STG2 = 3'd3,
        BS_FW   = 3'd4
    } boot_state_e;

    typedef enum logic [1:0] {
        DL_NONE   = 2'd0,
        DL_STAGE2 = 2'd1,
        DL_PLL    = 2'd2,
        DL_FW     = 2'd3
    } dl_kind_e;

    typedef enum logic [3:0] {
        PH_OFF, PH_CORE, PH_IO, PH_WAIT_ROM,
        PH_S2_GO, PH_S2_RUN, PH_WAIT_LDR,
        PH_PLL_A_GO, PH_PLL_A_RUN, PH_PLL_B_GO, PH_PLL_B_RUN,
        PH_FW_GO, PH_FW_RUN, PH_READY
    } phase_e;

    typedef struct packed {
        boot_state_e st;
        logic        core_en;
        logic        io_en;
        logic        in_rst;
        dl_kind_e    kind;
        logic        start;
        logic        waiting;
    } phase_out_t;

    localparam logic [3:0] DIV_LOADER = 4'd10;
    localparam logic [3:0] DIV_SLOW   = 4'd6;
    localparam logic [3:0] DIV_PLLSRC = 4'd0;

    function automatic phase_out_t decode_phase(phase_e ph);
        phase_out_t o;
        o = '{st: BS_OFF, core_en: 1'b1, io_en: 1'b1, in_rst: 1'b0,
              kind: DL_NONE, start: 1'b0, waiting: 1'b0};
        case (ph)
            PH_OFF:       begin o.core_en = 1'b0; o.io_en = 1'b0; o.in_rst = 1'b1; end
            PH_CORE:      begin o.io_en = 1'b0; o.in_rst = 1'b1; end
            PH_IO:        o.in_rst = 1'b1;
            PH_WAIT_ROM:  begin o.st = BS_OOR; o.waiting = 1'b1; end
            PH_S2_GO:     begin o.st = BS_BROM; o.kind = DL_STAGE2; o.start = 1'b1; end
            PH_S2_RUN:    begin o.st = BS_BROM; o.kind = DL_STAGE2; end
            PH_WAIT_LDR:  begin o.st = BS_BROM; o.waiting = 1'b1; end
            PH_PLL_A_GO,
            PH_PLL_B_GO:  begin o.st = BS_STG2; o.kind = DL_PLL; o.start = 1'b1; end
            PH_PLL_A_RUN,
            PH_PLL_B_RUN: begin o.st = BS_STG2; o.kind = DL_PLL; end
            PH_FW_GO:     begin o.st = BS_STG2; o.kind = DL_FW; o.start = 1'b1; end
            PH_FW_RUN:    begin o.st = BS_STG2; o.kind = DL_FW; end
            PH_READY:     o.st = BS_FW;
            default:      begin o.core_en = 1'b0; o.io_en = 1'b0; o.in_rst = 1'b1; end
        endcase
        return o;
    endfunction

    function automatic logic irq_window(boot_state_e s);
        return (s == BS_OOR) || (s == BS_BROM) || (s == BS_STG2);
    endfunction

endpackage

// File: rtl/dsp_irq_edge.sv
module dsp_irq_edge (
    input  logic clk,
    input  logic rst,
    input  logic irq_n,
    output logic fall
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= irq_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall = s3 & ~s2;
endmodule

// File: rtl/dsp_wait_timer.sv
module dsp_wait_timer #(
    parameter int unsigned CYC_PER_MS = 200000,
    parameter int unsigned TMO_MS     = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);
    localparam int unsigned TMO_CYC = CYC_PER_MS * TMO_MS;
    localparam int unsigned CNT_W   = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign hit = run && (cnt == LAST);
endmodule

// File: rtl/dsp_spi_clk_sel.sv
module dsp_spi_clk_sel
    import dsp_boot_pkg::*;
#(
    parameter int unsigned RATE_W = 32
) (
    input  dl_kind_e          kind,
    input  logic              pll_run,
    input  logic [RATE_W-1:0] max_hz,
    input  logic [RATE_W-1:0] board_hz,
    output logic [3:0]        div,
    output logic [RATE_W-1:0] pll_hz
);
    always_comb begin
        case (kind)
            DL_STAGE2: div = DIV_LOADER;
            DL_PLL:    div = DIV_SLOW;
            DL_FW:     div = pll_run ? DIV_PLLSRC : DIV_SLOW;
            default:   div = 4'd0;
        endcase
    end

    assign pll_hz = ((board_hz != '0) && (board_hz < max_hz)) ? board_hz : max_hz;
endmodule

// File: rtl/dsp_boot_seq.sv
module dsp_boot_seq
    import dsp_boot_pkg::*;
#(
    parameter int unsigned RATE_W        = 32,
    parameter int unsigned CYC_PER_MS    = 200000,
    parameter int unsigned TMO_MS        = 20,
    parameter int unsigned MAX_SYSCLK_HZ = 26000000,
    parameter logic        RST_ACTIVE    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_req,
    input  logic              halt_req,
    input  logic [RATE_W-1:0] sysclk_hz,
    input  logic [RATE_W-1:0] max_spi_hz,
    input  logic [RATE_W-1:0] board_max_hz,
    input  logic              dsp_irq_n,
    input  logic              dl_done,
    input  logic              dl_err,
    input  logic              chk_bad,
    input  logic              chk_pll_lock,
    output logic [2:0]        boot_state,
    output logic              core_sup_en,
    output logic              io_sup_en,
    output logic              dsp_rst,
    output logic              dl_start,
    output logic [1:0]        dl_kind,
    output logic [3:0]        spi_div,
    output logic [RATE_W-1:0] spi_pll_hz,
    output logic              pll_running,
    output logic              boot_fail,
    output logic              irq_timeout
);
    localparam logic [RATE_W-1:0] SYSCLK_LIMIT = RATE_W'(MAX_SYSCLK_HZ);

    phase_e     ph, ph_nxt;
    phase_out_t dec;
    logic       irq_fall, tmo_hit, got_irq;
    logic       pend_q, fail_q, tmo_q, pll_q;
    logic       fail_set, tmo_set, flags_clr, pll_load;

    assign dec = decode_phase(ph);

    dsp_irq_edge u_irq (
        .clk   (clk),
        .rst   (rst),
        .irq_n (dsp_irq_n),
        .fall  (irq_fall)
    );

    dsp_wait_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .TMO_MS     (TMO_MS)
    ) u_tmr (
        .clk (clk),
        .rst (rst),
        .run (dec.waiting),
        .hit (tmo_hit)
    );

    dsp_spi_clk_sel #(
        .RATE_W (RATE_W)
    ) u_clk (
        .kind     (dec.kind),
        .pll_run  (pll_q),
        .max_hz   (max_spi_hz),
        .board_hz (board_max_hz),
        .div      (spi_div),
        .pll_hz   (spi_pll_hz)
    );

    assign got_irq = pend_q | irq_fall;

    always_comb begin
        ph_nxt    = ph;
        fail_set  = 1'b0;
        tmo_set   = 1'b0;
        flags_clr = 1'b0;
        pll_load  = 1'b0;
        if (ph != PH_OFF && halt_req) begin
            ph_nxt = PH_OFF;
        end else begin
            case (ph)
                PH_OFF: if (boot_req) begin
                    if (sysclk_hz > SYSCLK_LIMIT) begin
                        fail_set = 1'b1;
                    end else begin
                        flags_clr = 1'b1;
                        ph_nxt    = PH_CORE;
                    end
                end
                PH_CORE:     ph_nxt = PH_IO;
                PH_IO:       ph_nxt = PH_WAIT_ROM;
                PH_WAIT_ROM: if (got_irq || tmo_hit) begin
                    tmo_set = ~got_irq;
                    ph_nxt  = PH_S2_GO;
                end
                PH_S2_GO:    ph_nxt = PH_S2_RUN;
                PH_S2_RUN:   if (dl_done) begin
                    if (dl_err || chk_bad) fail_set = 1'b1;
                    else                   ph_nxt   = PH_WAIT_LDR;
                end
                PH_WAIT_LDR: if (got_irq || tmo_hit) begin
                    tmo_set = ~got_irq;
                    ph_nxt  = (max_spi_hz != '0) ? PH_PLL_A_GO : PH_FW_GO;
                end
                PH_PLL_A_GO:  ph_nxt = PH_PLL_A_RUN;
                PH_PLL_A_RUN: if (dl_done) begin
                    if (dl_err) fail_set = 1'b1;
                    else        ph_nxt   = PH_PLL_B_GO;
                end
                PH_PLL_B_GO:  ph_nxt = PH_PLL_B_RUN;
                PH_PLL_B_RUN: if (dl_done) begin
                    if (dl_err) begin
                        fail_set = 1'b1;
                    end else begin
                        pll_load = 1'b1;
                        ph_nxt   = PH_FW_GO;
                    end
                end
                PH_FW_GO:  ph_nxt = PH_FW_RUN;
                PH_FW_RUN: if (dl_done) begin
                    if (dl_err || chk_bad) fail_set = 1'b1;
                    else                   ph_nxt   = PH_READY;
                end
                default: ph_nxt = ph;
            endcase
            if (fail_set) ph_nxt = PH_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_OFF;
            pend_q <= 1'b0;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
            pll_q  <= 1'b0;
        end else begin
            ph <= ph_nxt;

            if (flags_clr)     fail_q <= 1'b0;
            else if (fail_set) fail_q <= 1'b1;

            if (flags_clr)    tmo_q <= 1'b0;
            else if (tmo_set) tmo_q <= 1'b1;

            if (ph_nxt == PH_OFF) pll_q <= 1'b0;
            else if (pll_load)    pll_q <= chk_pll_lock;

            if (ph_nxt == PH_OFF)                   pend_q <= 1'b0;
            else if (dec.waiting && got_irq)        pend_q <= 1'b0;
            else if (irq_fall && irq_window(dec.st)) pend_q <= 1'b1;
        end
    end

    assign boot_state  = dec.st;
    assign core_sup_en = dec.core_en;
    assign io_sup_en   = dec.io_en;
    assign dsp_rst     = dec.in_rst ? RST_ACTIVE : ~RST_ACTIVE;
    assign dl_start    = dec.start;
    assign dl_kind     = dec.kind;
    assign pll_running = pll_q;
    assign boot_fail   = fail_q;
    assign irq_timeout = tmo_q;
endmodule

// File: rtl/dsp_boot_chk.sv
module dsp_boot_chk #(
    parameter logic RST_ACTIVE = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] boot_state,
    input logic       core_sup_en,
    input logic       io_sup_en,
    input logic       dsp_rst,
    input logic       dl_start,
    input logic [1:0] dl_kind,
    input logic       dl_done,
    input logic [3:0] spi_div,
    input logic       pll_running,
    input logic       boot_fail,
    input logic       irq_timeout
);
    // R1
    state_step_chk: assert property (@(posedge clk) disable iff (rst)
        (boot_state != $past(boot_state)) |->
            (boot_state == 3'd0 || boot_state == $past(boot_state) + 3'd1));

    // R2
    rail_order_chk: assert property (@(posedge clk) disable iff (rst)
        io_sup_en |-> core_sup_en);

    // R2
    rails_on_chk: assert property (@(posedge clk) disable iff (rst)
        (boot_state != 3'd0) |-> (core_sup_en && io_sup_en && dsp_rst == ~RST_ACTIVE));

    // R4
    timeout_dest_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_timeout) |-> (boot_state == 3'd2 || boot_state == 3'd3));

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dl_start |=> !dl_start);

    // R6
    pll_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_running) |-> ($past(dl_done) && $past(dl_kind) == 2'd2));

    // R7
    fw_div_chk: assert property (@(posedge clk) disable iff (rst)
        (dl_kind == 2'd3 && pll_running) |-> (spi_div == 4'd0));

    // R8
    fail_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_fail) |-> (boot_state == 3'd0 && !core_sup_en && !io_sup_en
                              && dsp_rst == RST_ACTIVE && !pll_running));
endmodule

bind dsp_boot_seq dsp_boot_chk #(.RST_ACTIVE(RST_ACTIVE)) u_boot_chk (
    .clk         (clk),
    .rst         (rst),
    .boot_state  (boot_state),
    .core_sup_en (core_sup_en),
    .io_sup_en   (io_sup_en),
    .dsp_rst     (dsp_rst),
    .dl_start    (dl_start),
    .dl_kind     (dl_kind),
    .dl_done     (dl_done),
    .spi_div     (spi_div),
    .pll_running (pll_running),
    .boot_fail   (boot_fail),
    .irq_timeout (irq_timeout)
);

// File: tb/tb_dsp_boot_seq.sv
`timescale 1ns/1ps
module tb_dsp_boot_seq;
    localparam int CPM = 5;
    localparam int TMO = CPM * 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_req = 0, halt_req = 0;
    logic [31:0] sysclk_hz = 32'd24000000, max_spi_hz = 32'd26000000, board_max_hz = 32'd0;
    logic        dsp_irq_n = 1'b1;
    logic        dl_done = 0, dl_err = 0, chk_bad = 0, chk_pll_lock = 0;
    logic [2:0]  boot_state;
    logic        core_sup_en, io_sup_en, dsp_rst, dl_start;
    logic [1:0]  dl_kind;
    logic [3:0]  spi_div;
    logic [31:0] spi_pll_hz;
    logic        pll_running, boot_fail, irq_timeout;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    dsp_boot_seq #(.CYC_PER_MS(CPM)) dut (
        .clk(clk), .rst(rst), .boot_req(boot_req), .halt_req(halt_req),
        .sysclk_hz(sysclk_hz), .max_spi_hz(max_spi_hz), .board_max_hz(board_max_hz),
        .dsp_irq_n(dsp_irq_n), .dl_done(dl_done), .dl_err(dl_err), .chk_bad(chk_bad),
        .chk_pll_lock(chk_pll_lock), .boot_state(boot_state), .core_sup_en(core_sup_en),
        .io_sup_en(io_sup_en), .dsp_rst(dsp_rst), .dl_start(dl_start), .dl_kind(dl_kind),
        .spi_div(spi_div), .spi_pll_hz(spi_pll_hz), .pll_running(pll_running),
        .boot_fail(boot_fail), .irq_timeout(irq_timeout)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mp = 0, mcnt = 0;
    bit mpend = 0, mfail = 0, mtmo = 0, mpll = 0;
    bit h1 = 1, h2 = 1, h3 = 1;

    function automatic int m_state(int p);
        if (p <= 2) return 0;
        if (p == 3) return 1;
        if (p <= 6) return 2;
        if (p <= 12) return 3;
        return 4;
    endfunction

    function automatic int m_kind(int p);
        if (p == 4 || p == 5) return 1;
        if (p >= 7 && p <= 10) return 2;
        if (p == 11 || p == 12) return 3;
        return 0;
    endfunction

    function automatic bit m_wait(int p);
        return (p == 3) || (p == 6);
    endfunction

    function automatic int m_div(int p, bit pl);
        case (m_kind(p))
            1: return 10;
            2: return 6;
            3: return pl ? 0 : 6;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mp = 0; mcnt = 0; mpend = 0; mfail = 0; mtmo = 0; mpll = 0;
            h1 = 1; h2 = 1; h3 = 1;
        end else begin
            bit fall, got, fl;
            int nx;
            fall = h3 && !h2;
            got  = mpend || fall;
            nx = mp;
            fl = 0;
            if (mp != 0 && halt_req) nx = 0;
            else begin
                case (mp)
                    0: if (boot_req) begin
                        if (sysclk_hz > 32'd26000000) mfail = 1;
                        else begin nx = 1; mfail = 0; mtmo = 0; end
                    end
                    1: nx = 2;
                    2: nx = 3;
                    3: if (got) nx = 4; else if (mcnt == TMO - 1) begin nx = 4; mtmo = 1; end
                    4: nx = 5;
                    5: if (dl_done) begin if (dl_err || chk_bad) fl = 1; else nx = 6; end
                    6: if (got || mcnt == TMO - 1) begin
                        if (!got) mtmo = 1;
                        nx = (max_spi_hz != 0) ? 7 : 11;
                    end
                    7: nx = 8;
                    8: if (dl_done) begin if (dl_err) fl = 1; else nx = 9; end
                    9: nx = 10;
                    10: if (dl_done) begin if (dl_err) fl = 1; else begin mpll = chk_pll_lock; nx = 11; end end
                    11: nx = 12;
                    12: if (dl_done) begin if (dl_err || chk_bad) fl = 1; else nx = 13; end
                    default: nx = mp;
                endcase
                if (fl) begin nx = 0; mfail = 1; end
            end
            if (nx == 0) mpll = 0;
            if (nx == 0) mpend = 0;
            else if (m_wait(mp) && got) mpend = 0;
            else if (fall && m_state(mp) >= 1 && m_state(mp) <= 3) mpend = 1;
            if (!m_wait(mp)) mcnt = 0;
            else if (mcnt != TMO - 1) mcnt++;
            h3 = h2; h2 = h1; h1 = dsp_irq_n;
            mp = nx;
        end
    end

    function automatic longint m_pll_hz();
        if (board_max_hz != 0 && board_max_hz < max_spi_hz) return board_max_hz;
        return max_spi_hz;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            chk("R1 boot_state", boot_state, m_state(mp));
            chk("R2 core_sup_en", core_sup_en, mp >= 1);
            chk("R2 io_sup_en", io_sup_en, mp >= 2);
            chk("R2 dsp_rst", dsp_rst, (mp <= 2) ? 0 : 1);
            chk("R5 dl_start", dl_start, (mp == 4 || mp == 7 || mp == 9 || mp == 11));
            chk("R5 dl_kind", dl_kind, m_kind(mp));
            chk("R7 spi_div", spi_div, m_div(mp, mpll));
            chk("R7 spi_pll_hz", spi_pll_hz, m_pll_hz());
            chk("R6 pll_running", pll_running, mpll);
            chk("R8 boot_fail", boot_fail, mfail);
            chk("R4 irq_timeout", irq_timeout, mtmo);
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_boot();
        boot_req = 1; idle(1); boot_req = 0;
    endtask

    task automatic pulse_halt();
        halt_req = 1; idle(1); halt_req = 0;
    endtask

    task automatic irq_pulse();
        dsp_irq_n = 0; idle(3); dsp_irq_n = 1;
    endtask

    task automatic serve(input int lat, input bit err, input bit bad, input bit lock, input bit irq_mid);
        while (dl_start !== 1'b1) idle(1);
        if (irq_mid) irq_pulse();
        idle(lat);
        dl_done = 1; dl_err = err; chk_bad = bad; chk_pll_lock = lock;
        idle(1);
        dl_done = 0; dl_err = 0; chk_bad = 0; chk_pll_lock = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset state", boot_state, 0);
        chk("R2 reset rails", {core_sup_en, io_sup_en}, 0);
        chk("R2 reset level", dsp_rst, 0);
        #1 rst = 0;
        idle(2);

        // A: full boot with interrupts, PLL locks, board limit lower
        board_max_hz = 32'd20000000;
        pulse_boot();
        idle(4); irq_pulse();
        serve(3, 0, 0, 0, 0);
        irq_pulse();
        serve(2, 0, 0, 0, 0);
        serve(2, 0, 0, 1, 0);
        serve(4, 0, 0, 0, 0);
        idle(2);
        chk("R11 firmware state", boot_state, 4);
        chk("R6 pll locked", pll_running, 1);
        chk("R7 board limit", spi_pll_hz, 20000000);
        chk("R4 no timeout", irq_timeout, 0);
        pulse_boot(); idle(2);
        chk("R10 boot ignored", boot_state, 4);
        pulse_halt();
        chk("R10 halt", boot_state, 0);
        chk("R10 no fail", boot_fail, 0);

        // B: no interrupts, no PLL
        max_spi_hz = 32'd0;
        pulse_boot();
        serve(2, 0, 0, 0, 0);
        serve(3, 0, 0, 0, 0);
        idle(1);
        chk("R4 timeout flag", irq_timeout, 1);
        chk("R6 pll skipped", pll_running, 0);
        chk("R11 firmware state", boot_state, 4);
        pulse_halt();

        // C: irq while off dropped, irq during stage2 held, PLL no lock, chk_bad ignored
        max_spi_hz = 32'd26000000; board_max_hz = 32'd0;
        irq_pulse(); idle(3);
        pulse_boot();
        serve(6, 0, 0, 0, 1);
        idle(1);
        chk("R3 held irq", boot_state, 3);
        chk("R3 held irq start", dl_start, 1);
        chk("R3 off irq dropped", irq_timeout, 1);
        serve(2, 0, 1, 0, 0);
        serve(2, 0, 0, 0, 0);
        serve(2, 0, 0, 0, 0);
        idle(1);
        chk("R6 bad ignored", boot_state, 4);
        chk("R6 no lock", pll_running, 0);
        chk("R7 no board limit", spi_pll_hz, 26000000);
        pulse_halt();

        // D: stage2 bad reply
        pulse_boot(); idle(4); irq_pulse();
        serve(2, 0, 1, 0, 0);
        chk("R8 state off", boot_state, 0);
        chk("R8 rails off", {core_sup_en, io_sup_en}, 0);
        chk("R8 reset", dsp_rst, 0);
        chk("R8 fail flag", boot_fail, 1);

        // E: PLL transport error
        pulse_boot(); idle(4); irq_pulse();
        serve(2, 0, 0, 0, 0); irq_pulse();
        serve(2, 1, 0, 0, 0);
        chk("R8 pll err", boot_state, 0);
        chk("R11 fail cleared then set", boot_fail, 1);

        // F: firmware bad reply
        max_spi_hz = 32'd0;
        pulse_boot(); idle(4); irq_pulse();
        serve(2, 0, 0, 0, 0); irq_pulse();
        serve(2, 0, 1, 0, 0);
        chk("R8 fw bad", boot_state, 0);

        // G: sysclk limit
        sysclk_hz = 32'd26000001;
        pulse_boot(); idle(2);
        chk("R9 refused", core_sup_en, 0);
        chk("R9 refused flag", boot_fail, 1);
        sysclk_hz = 32'd26000000;
        pulse_boot();
        chk("R9 limit accepted", core_sup_en, 1);
        chk("R11 fail cleared", boot_fail, 0);
        idle(3);
        pulse_halt();
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule